// File: doc/BRIEF.md
# Embedded Program/Erase Sequencer

This block carries out the internal algorithm of a non-volatile word memory once a program or whole-array erase request has been accepted by the command front end. It owns a small model of the storage array. A program applies timed pulses to one word, verifies it after every pulse and gives up after a pulse limit. An erase first drives every word to zero, one word at a time with the same verify-and-retry loop, and only then applies whole-array erase pulses, each followed by a scan that expects every word to read all ones.

The block reports three registered results: a busy flag, the kind of the last accepted operation, and a sticky timeout flag. Pulse widths and retry limits are parameters in clock cycles. A test input forces the verify of one chosen word to fail, so that the retry and timeout paths can be reached on demand. A read port returns any stored word at any time.

Top module: `pe_sequencer`

## Requirements
- R1: After hardware reset, busy, op_erase and timeout are 0 and every word reads all ones (FFFFh).
- R2: A program stores old AND data in the target word: bits can only go from 1 to 0, a 1 in the data leaves the stored bit unchanged, and no other word changes.
- R3: A program whose verify passes keeps busy high for exactly PGM_W+1 cycles, counted from the clock edge that samples start.
- R4: When a program verify keeps failing, the block applies exactly PGM_MAX pulses, keeps busy high for PGM_MAX*(PGM_W+1) cycles, then drops busy and raises timeout in the same edge; op_erase reads 0 for a program and 1 for an erase.
- R5: A passing erase keeps busy high for WORDS*(PGM_W+1)+ERS_W+WORDS cycles (one pulse and check per word of preprogram, one erase pulse, one check per word) and leaves every word at FFFFh.
- R6: If the preprogram verify of word k keeps failing, the erase ends with timeout after (k+PGM_MAX)*(PGM_W+1) cycles, with words 0 to k at zero, the rest untouched and no erase pulse applied.
- R7: If the erase verify of word k keeps failing, the block applies exactly ERS_MAX erase pulses, each followed by a scan from word 0 to word k, so busy lasts WORDS*(PGM_W+1)+ERS_MAX*(ERS_W+k+1) cycles before timeout.
- R8: While busy, start and cmd_reset have no effect: the running operation keeps its length, its kind and its result.
- R9: Hardware reset clears busy and timeout at once, without waiting for a clock edge, and returns the array to all ones.
- R10: timeout stays high while idle until cmd_reset or an accepted start; either clears it on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| start | input | 1 | Accept a new operation when idle |
| op_sel | input | 1 | Operation of the request: 0 program, 1 whole-array erase |
| addr_in | input | AW | Target word of a program |
| data_in | input | DW | Data of a program |
| cmd_reset | input | 1 | Reset command; clears timeout when idle, ignored when busy |
| force_fail | input | 1 | Test hook: make verify of force_addr fail |
| force_addr | input | AW | Word whose verify is forced to fail |
| rd_addr | input | AW | Read port address |
| rd_data | output | DW | Stored word at rd_addr |
| busy | output | 1 | Algorithm running |
| op_erase | output | 1 | Kind of the last accepted operation: 1 erase, 0 program |
| timeout | output | 1 | Last operation exhausted its pulse limit |

## Verification
Busy rises on the edge that samples start and falls on the edge of the final verify, so every operation length is stated as a count of cycles with busy high, computed from the width and limit parameters and the forced word; the bench counts busy at each falling edge and compares the count with that formula. Timeout rises on the same edge as busy falls and is checked at the falling edge right after it. Array contents are read through the combinational read port in the low clock phase after busy has dropped, word by word, against a model held in the bench. Reset effects are checked a fraction of a cycle after rst_n falls, before any clock edge.

// File: rtl/pe_seq_pkg.sv
package pe_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PGM_PULSE,
      ST_PGM_CHECK,
      ST_ERS_PULSE,
      ST_ERS_CHECK
   } seq_state_t;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pe_array.sv
module pe_array #(
   parameter int unsigned DW    = 16,
   parameter int unsigned WORDS = 256,
   localparam int unsigned AW   = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pgm_en,
   input  logic [AW-1:0] pgm_addr,
   input  logic [DW-1:0] pgm_mask,
   input  logic          ers_en,
   input  logic [AW-1:0] vf_addr,
   output logic [DW-1:0] vf_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);

   logic [DW-1:0] mem [WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(WORDS); i++) mem[i] <= '1;
      end else if (ers_en) begin
         for (int i = 0; i < int'(WORDS); i++) mem[i] <= '1;
      end else if (pgm_en) begin
         mem[pgm_addr] <= mem[pgm_addr] & pgm_mask;
      end
   end

   assign vf_data = mem[vf_addr];
   assign rd_data = mem[rd_addr];

endmodule

// File: rtl/pe_pulse_timer.sv
module pe_pulse_timer #(
   parameter int unsigned TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [TW-1:0] width,
   output logic          expire
);

   logic [TW-1:0] cnt;

   assign expire = run && (cnt == width - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (!run)     cnt <= '0;
      else if (!expire)  cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/pe_ctrl.sv
module pe_ctrl
   import pe_seq_pkg::*;
#(
   parameter int unsigned DW        = 16,
   parameter int unsigned WORDS     = 256,
   parameter int unsigned PGM_MAX   = 16,
   parameter int unsigned ERS_MAX   = 8,
   parameter bit          TEST_HOOK = 1'b1,
   localparam int unsigned AW       = $clog2(WORDS),
   localparam int unsigned CW       = $clog2(max_u(PGM_MAX, ERS_MAX) + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          op_sel,
   input  logic [AW-1:0] addr_in,
   input  logic [DW-1:0] data_in,
   input  logic          cmd_reset,
   input  logic          force_fail,
   input  logic [AW-1:0] force_addr,
   input  logic          tmr_expire,
   input  logic [DW-1:0] vf_data,
   output logic          in_pulse,
   output logic          long_pulse,
   output logic          pgm_en,
   output logic [AW-1:0] pgm_addr,
   output logic [DW-1:0] pgm_mask,
   output logic          ers_en,
   output logic [AW-1:0] vf_addr,
   output logic          busy,
   output logic          op_erase,
   output logic          timeout
);

   seq_state_t    state;
   logic [AW-1:0] cur_addr;
   logic [DW-1:0] cur_data;
   logic [CW-1:0] pcount;
   logic          forced;
   logic          pgm_ok;
   logic          ers_ok;
   logic          last_word;

   generate
      if (TEST_HOOK) begin : g_hook
         assign forced = force_fail && (force_addr == cur_addr);
      end else begin : g_nohook
         assign forced = 1'b0;
      end
   endgenerate

   assign pgm_ok     = ((vf_data & ~cur_data) == '0) && !forced;
   assign ers_ok     = (vf_data == '1) && !forced;
   assign last_word  = (cur_addr == AW'(WORDS - 1));
   assign in_pulse   = (state == ST_PGM_PULSE) || (state == ST_ERS_PULSE);
   assign long_pulse = (state == ST_ERS_PULSE);
   assign pgm_en     = (state == ST_PGM_PULSE) && tmr_expire;
   assign ers_en     = (state == ST_ERS_PULSE) && tmr_expire;
   assign pgm_addr   = cur_addr;
   assign pgm_mask   = cur_data;
   assign vf_addr    = cur_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cur_addr <= '0;
         cur_data <= '0;
         pcount   <= '0;
         busy     <= 1'b0;
         op_erase <= 1'b0;
         timeout  <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  busy     <= 1'b1;
                  timeout  <= 1'b0;
                  pcount   <= '0;
                  op_erase <= op_sel;
                  state    <= ST_PGM_PULSE;
                  cur_addr <= op_sel ? '0 : addr_in;
                  cur_data <= op_sel ? '0 : data_in;
               end else if (cmd_reset) begin
                  timeout <= 1'b0;
               end
            end
            ST_PGM_PULSE: begin
               if (tmr_expire) begin
                  pcount <= pcount + 1'b1;
                  state  <= ST_PGM_CHECK;
               end
            end
            ST_PGM_CHECK: begin
               if (pgm_ok) begin
                  pcount <= '0;
                  if (!op_erase) begin
                     state    <= ST_IDLE;
                     busy     <= 1'b0;
                     cur_addr <= '0;
                  end else if (last_word) begin
                     state    <= ST_ERS_PULSE;
                     cur_addr <= '0;
                  end else begin
                     state    <= ST_PGM_PULSE;
                     cur_addr <= cur_addr + 1'b1;
                  end
               end else if (pcount >= CW'(PGM_MAX)) begin
                  state    <= ST_IDLE;
                  busy     <= 1'b0;
                  timeout  <= 1'b1;
                  cur_addr <= '0;
               end else begin
                  state <= ST_PGM_PULSE;
               end
            end
            ST_ERS_PULSE: begin
               if (tmr_expire) begin
                  pcount   <= pcount + 1'b1;
                  cur_addr <= '0;
                  state    <= ST_ERS_CHECK;
               end
            end
            ST_ERS_CHECK: begin
               if (ers_ok) begin
                  if (last_word) begin
                     state    <= ST_IDLE;
                     busy     <= 1'b0;
                     cur_addr <= '0;
                  end else begin
                     cur_addr <= cur_addr + 1'b1;
                  end
               end else if (pcount >= CW'(ERS_MAX)) begin
                  state    <= ST_IDLE;
                  busy     <= 1'b0;
                  timeout  <= 1'b1;
                  cur_addr <= '0;
               end else begin
                  state <= ST_ERS_PULSE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pe_sequencer.sv
module pe_sequencer
   import pe_seq_pkg::*;
#(
   parameter int unsigned DW        = 16,
   parameter int unsigned WORDS     = 256,
   parameter int unsigned PGM_W     = 8,
   parameter int unsigned ERS_W     = 32,
   parameter int unsigned PGM_MAX   = 16,
   parameter int unsigned ERS_MAX   = 8,
   parameter bit          TEST_HOOK = 1'b1,
   localparam int unsigned AW       = $clog2(WORDS),
   localparam int unsigned TW       = $clog2(max_u(PGM_W, ERS_W) + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          op_sel,
   input  logic [AW-1:0] addr_in,
   input  logic [DW-1:0] data_in,
   input  logic          cmd_reset,
   input  logic          force_fail,
   input  logic [AW-1:0] force_addr,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   output logic          busy,
   output logic          op_erase,
   output logic          timeout
);

   generate
      if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
         $error("pe_sequencer: WORDS must be a power of two, at least 2");
      end
      if (PGM_W < 1 || ERS_W < 1) begin : g_bad_width
         $error("pe_sequencer: pulse widths must be at least one cycle");
      end
      if (PGM_MAX < 1 || ERS_MAX < 1) begin : g_bad_limit
         $error("pe_sequencer: pulse limits must be at least one");
      end
   endgenerate

   logic          in_pulse;
   logic          long_pulse;
   logic          tmr_expire;
   logic [TW-1:0] pulse_width;
   logic          pgm_en;
   logic [AW-1:0] pgm_addr;
   logic [DW-1:0] pgm_mask;
   logic          ers_en;
   logic [AW-1:0] vf_addr;
   logic [DW-1:0] vf_data;

   assign pulse_width = long_pulse ? TW'(ERS_W) : TW'(PGM_W);

   pe_pulse_timer #(.TW(TW)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (in_pulse),
      .width  (pulse_width),
      .expire (tmr_expire)
   );

   pe_array #(.DW(DW), .WORDS(WORDS)) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .pgm_en   (pgm_en),
      .pgm_addr (pgm_addr),
      .pgm_mask (pgm_mask),
      .ers_en   (ers_en),
      .vf_addr  (vf_addr),
      .vf_data  (vf_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data)
   );

   pe_ctrl #(
      .DW(DW), .WORDS(WORDS), .PGM_MAX(PGM_MAX), .ERS_MAX(ERS_MAX), .TEST_HOOK(TEST_HOOK)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .op_sel     (op_sel),
      .addr_in    (addr_in),
      .data_in    (data_in),
      .cmd_reset  (cmd_reset),
      .force_fail (force_fail),
      .force_addr (force_addr),
      .tmr_expire (tmr_expire),
      .vf_data    (vf_data),
      .in_pulse   (in_pulse),
      .long_pulse (long_pulse),
      .pgm_en     (pgm_en),
      .pgm_addr   (pgm_addr),
      .pgm_mask   (pgm_mask),
      .ers_en     (ers_en),
      .vf_addr    (vf_addr),
      .busy       (busy),
      .op_erase   (op_erase),
      .timeout    (timeout)
   );

endmodule

// File: rtl/pe_sequencer_chk.sv
module pe_sequencer_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic cmd_reset,
   input logic busy,
   input logic op_erase,
   input logic timeout
);

   // R3: an accepted start raises busy on the next edge
   a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);

   // R8: a start while busy does not change the operation kind
   a_r8_busy_start_keeps_op: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(op_erase));

   // R4: timeout is only ever seen with the sequencer idle
   a_r4_timeout_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> !busy);

   // R4: timeout rises in the same edge that ends the operation
   a_r4_timeout_ends_op: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout) |-> $fell(busy));

   // R10: timeout holds while nothing clears it
   a_r10_timeout_held: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout && !start && !cmd_reset) |=> timeout);

   // R10: reset command or accepted start clears timeout
   a_r10_timeout_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && (start || cmd_reset)) |=> !timeout);

endmodule

bind pe_sequencer pe_sequencer_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .cmd_reset (cmd_reset),
   .busy      (busy),
   .op_erase  (op_erase),
   .timeout   (timeout)
);

// File: tb/pe_sequencer_tb.sv
module pe_sequencer_tb;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int W  = 16;
   localparam int AW = 4;
   localparam int PW = 3;
   localparam int EW = 5;
   localparam int PM = 4;
   localparam int EM = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          op_sel = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic [DW-1:0] data_in = '0;
   logic          cmd_reset = 1'b0;
   logic          force_fail = 1'b0;
   logic [AW-1:0] force_addr = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          busy;
   logic          op_erase;
   logic          timeout;

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] model [W];

   always #(CLK_PERIOD/2) clk = ~clk;

   pe_sequencer #(
      .DW(DW), .WORDS(W), .PGM_W(PW), .ERS_W(EW), .PGM_MAX(PM), .ERS_MAX(EM), .TEST_HOOK(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .addr_in(addr_in),
      .data_in(data_in), .cmd_reset(cmd_reset), .force_fail(force_fail),
      .force_addr(force_addr), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
      .op_erase(op_erase), .timeout(timeout)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_array(input string req);
      for (int i = 0; i < W; i++) begin
         rd_addr = AW'(i);
         #1;
         chk(req, int'(rd_data), int'(model[i]));
      end
   endtask

   // Starts an operation and counts falling edges with busy high.
   // arm_at: raise force_fail at that busy count (0 = never).
   // poke_at: drive start and cmd_reset for one cycle at that count (0 = never).
   task automatic run_op(input bit op, input int a, input int d, input int arm_at,
                         input int poke_at, output int cycles);
      @(negedge clk);
      start = 1'b1; op_sel = op; addr_in = AW'(a); data_in = DW'(d);
      @(negedge clk);
      start = 1'b0;
      cycles = busy ? 1 : 0;
      while (busy && cycles < 5000) begin
         if (cycles == arm_at) force_fail = 1'b1;
         if (cycles == poke_at) begin
            start = 1'b1; op_sel = ~op; cmd_reset = 1'b1;
         end
         @(negedge clk);
         start = 1'b0; cmd_reset = 1'b0;
         if (busy) cycles++;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int cyc;
      for (int i = 0; i < W; i++) model[i] = 16'hFFFF;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 busy", int'(busy), 0);
      chk("R1 op_erase", int'(op_erase), 0);
      chk("R1 timeout", int'(timeout), 0);
      check_array("R1 array");
      rst_n = 1'b1;

      // R2/R3: program sweep, one walking zero per word
      for (int a = 0; a < W; a++) begin
         run_op(1'b0, a, 16'hFFFF ^ (16'h1 << a), 0, 0, cyc);
         model[a] &= 16'hFFFF ^ (16'h1 << a);
         chk("R3 program length", cyc, PW + 1);
         chk("R4 op_erase program", int'(op_erase), 0);
      end
      check_array("R2 walking zero");
      // R2: ones in the data cannot restore zeros; further zeros are added
      run_op(1'b0, 3, 16'hFFFF, 0, 0, cyc);
      chk("R3 program length ones", cyc, PW + 1);
      run_op(1'b0, 5, 16'h0F0F, 0, 0, cyc);
      model[5] &= 16'h0F0F;
      run_op(1'b0, 5, 16'hF0FF, 0, 0, cyc);
      model[5] &= 16'hF0FF;
      check_array("R2 and-only");

      // R8: start and reset command mid-program have no effect
      run_op(1'b0, 9, 16'h1234, 0, 2, cyc);
      model[9] &= 16'h1234;
      chk("R8 length", cyc, PW + 1);
      chk("R8 op kind", int'(op_erase), 0);
      chk("R8 timeout", int'(timeout), 0);
      check_array("R8 array");

      // R5: passing erase
      run_op(1'b1, 0, 0, 0, 0, cyc);
      for (int i = 0; i < W; i++) model[i] = 16'hFFFF;
      chk("R5 erase length", cyc, W * (PW + 1) + EW + W);
      chk("R5 op_erase", int'(op_erase), 1);
      chk("R5 timeout", int'(timeout), 0);
      check_array("R5 array");

      // R4: forced program failure
      force_addr = 4'd5; force_fail = 1'b1;
      run_op(1'b0, 5, 16'h00FF, 0, 0, cyc);
      model[5] &= 16'h00FF;
      chk("R4 timeout length", cyc, PM * (PW + 1));
      chk("R4 timeout flag", int'(timeout), 1);
      chk("R4 busy low", int'(busy), 0);
      check_array("R4 array");
      force_fail = 1'b0;

      // R10: held, then cleared by reset command
      repeat (5) @(negedge clk);
      chk("R10 timeout held", int'(timeout), 1);
      cmd_reset = 1'b1;
      @(negedge clk);
      cmd_reset = 1'b0;
      chk("R10 cleared by cmd_reset", int'(timeout), 0);

      // R10: cleared by an accepted start
      force_fail = 1'b1;
      run_op(1'b0, 5, 16'hFFFF, 0, 0, cyc);
      force_fail = 1'b0;
      chk("R10 timeout again", int'(timeout), 1);
      run_op(1'b0, 7, 16'h7777, 0, 0, cyc);
      model[7] &= 16'h7777;
      chk("R10 cleared by start", int'(timeout), 0);

      // R6: preprogram failure at word 6
      force_addr = 4'd6; force_fail = 1'b1;
      run_op(1'b1, 0, 0, 0, 0, cyc);
      force_fail = 1'b0;
      for (int i = 0; i <= 6; i++) model[i] = 16'h0000;
      chk("R6 length", cyc, (6 + PM) * (PW + 1));
      chk("R6 timeout", int'(timeout), 1);
      chk("R6 op_erase", int'(op_erase), 1);
      check_array("R6 array");

      // R7: erase verify failure at word 9, armed during the erase pulse
      force_addr = 4'd9;
      run_op(1'b1, 0, 0, W * (PW + 1) + 1, 0, cyc);
      force_fail = 1'b0;
      for (int i = 0; i < W; i++) model[i] = 16'hFFFF;
      chk("R7 length", cyc, W * (PW + 1) + EM * (EW + 10));
      chk("R7 timeout", int'(timeout), 1);
      check_array("R7 array");

      // R9: hardware reset in the middle of an erase
      run_op(1'b0, 2, 16'h0000, 0, 0, cyc);
      model[2] = 16'h0000;
      @(negedge clk);
      start = 1'b1; op_sel = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      chk("R9 busy before reset", int'(busy), 1);
      #2;
      rst_n = 1'b0;
      #1;
      chk("R9 busy cleared", int'(busy), 0);
      chk("R9 timeout cleared", int'(timeout), 0);
      for (int i = 0; i < W; i++) model[i] = 16'hFFFF;
      check_array("R9 array");
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R9 stays idle", int'(busy), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule